// File: doc/BRIEF.md
# Sticky Status and Coherent Measurement Read Port

This block is the read-only side of a small register file. Event strobes from elsewhere in the chip set bits in three status bytes. Each set bit stays set until the host reads the byte that holds it, and the read clears it. An active-low interrupt line goes low while any status bit is set and not suppressed by the mask input. The host can therefore poll the status bytes, or wait for the interrupt line and then read them.

Two 10-bit measurement values are published as byte pairs. The upper byte comes first in address order and the lower byte follows. Reading the upper byte takes a snapshot of the value, and the lower byte is then served from that snapshot. An auto-incrementing burst read therefore returns both halves of one sample, even while new conversions keep updating the live value.

A burst starts in the cycle where the read enable rises. That cycle uses the host address, and every following cycle with the enable still high reads the next address. Read data is registered and appears one cycle after the read cycle.

Top module: `stat_meas_rdport`

## Requirements
- R1: After synchronous reset, all status bits are 0, `chk_n` is 1, `rd_vld` and `rd_data` are 0, and both measurement values and their snapshots are 0.
- R2: `chk_n` is 0 exactly when some status bit is 1 and the matching `irq_mask` bit is 0 (mask bit 1 suppresses). A mask change has effect in the same cycle. An event is reflected one cycle after its strobe.
- R3: A 1 on bit k of `evt` sets status bit k at the next clock edge, and the bit stays 1 until it is read. If the event arrives in the same cycle as a read of its byte, the bit is still 1 after that read.
- R4: Status byte j (j = 0..2) sits at address j and holds `evt` bits [8j+7:8j]. A read returns the byte as it was before the read and clears every bit that had no event in that cycle. Reads of other addresses leave the byte unchanged.
- R5: Address map: 0x03 holds measurement 0 bits [9:8] in data bits [1:0] with the other bits 0, and 0x04 holds measurement 0 bits [7:0]. 0x05 and 0x06 hold measurement 1 in the same layout. Addresses 0x07 to 0x3F read as 0x00.
- R6: A `meas_upd[i]` pulse stores `meas_val[i]`, and a read issued in any later cycle sees the stored value.
- R7: A read of a pair's upper byte copies the stored value into that pair's snapshot. A read of the lower byte returns the snapshot, so a burst across the pair returns one sample even if an update lands between the two reads. A lower-byte read with no upper-byte read before it returns the last snapshot.
- R8: In the cycle where `rd_en` rises, the read uses `rd_addr`. Each further cycle with `rd_en` high reads the previous address plus one, wrapping from 0x3F to 0x00, and ignores `rd_addr`. Dropping `rd_en` ends the burst.
- R9: `rd_vld` is 1, and `rd_data` carries the byte, in the cycle after each read cycle. In all other cycles both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable; held high for a burst |
| rd_addr | input | 6 | Start address, used in the first cycle of a burst |
| evt | input | 24 | Event strobes, one per status bit |
| irq_mask | input | 24 | Interrupt suppression, 1 = bit ignored for `chk_n` |
| meas_upd | input | 2 | Per-measurement update strobe |
| meas_val | input | 2x10 | New measurement values, packed [1:0][9:0] |
| rd_data | output | 8 | Registered read byte |
| rd_vld | output | 1 | Read byte valid |
| chk_n | output | 1 | Active-low interrupt, low while any unmasked status bit is set |

## Verification
The hardest case to reach from the ports is a measurement update that lands between the upper-byte and lower-byte reads of a burst. It needs an update strobe timed to the exact cycle in which the burst counter sits on the upper byte. A second hard case is an event strobe arriving in the same cycle that its status byte is read. Directed steps place both collisions cycle by cycle. Random bursts with frequent update strobes and sparse events then produce many more of them. A bench model predicts every byte and every `chk_n` level from the requirements.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int STAT_BYTES = 3;
    localparam int NUM_MEAS   = 2;
    localparam int MEAS_W     = 10;
    localparam int MEAS_BASE  = 3;

    localparam int STAT_W = STAT_BYTES * DATA_W;
    localparam int IDX_W  = (STAT_BYTES > NUM_MEAS) ? $clog2(STAT_BYTES) : $clog2(NUM_MEAS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [MEAS_W-1:0] meas_t;

    localparam addr_t STAT_END = addr_t'(STAT_BYTES);
    localparam addr_t MEAS_A   = addr_t'(MEAS_BASE);
    localparam addr_t MEAS_END = addr_t'(MEAS_BASE + 2 * NUM_MEAS);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MHI,
        SEL_MLO
    } sel_e;

    typedef struct packed {
        logic             act;
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } rd_dec_t;

    function automatic rd_dec_t decode(addr_t a);
        rd_dec_t d;
        addr_t   off;
        d.act = 1'b1;
        d.sel = SEL_NONE;
        d.idx = '0;
        off   = a - MEAS_A;
        if (a < STAT_END) begin
            d.sel = SEL_STAT;
            d.idx = a[IDX_W-1:0];
        end else if (a >= MEAS_A && a < MEAS_END) begin
            d.idx = IDX_W'(off >> 1);
            d.sel = off[0] ? SEL_MLO : SEL_MHI;
        end
        return d;
    endfunction

    function automatic byte_t hi_byte(meas_t v);
        byte_t b;
        b = '0;
        b[MEAS_W-DATA_W-1:0] = v[MEAS_W-1:DATA_W];
        return b;
    endfunction

    function automatic byte_t lo_byte(meas_t v);
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/smr_rd_seq.sv
module smr_rd_seq
    import smr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_en,
    input  addr_t   rd_addr,
    output rd_dec_t dec
);
    logic  rd_en_q;
    addr_t cnt_q;
    addr_t ea;

    // a burst takes the host address only in its first cycle
    assign ea = (rd_en && !rd_en_q) ? rd_addr : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            rd_en_q <= rd_en;
            if (rd_en) cnt_q <= ea + addr_t'(1);
        end
    end

    always_comb begin
        dec     = decode(ea);
        dec.act = rd_en;
    end
endmodule

// File: rtl/smr_stat_bank.sv
module smr_stat_bank
    import smr_pkg::*;
#(
    parameter int NBYTES = STAT_BYTES,
    localparam int W     = NBYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      evt,
    input  logic [W-1:0]      mask,
    input  logic [NBYTES-1:0] clr,
    output logic [W-1:0]      status,
    output logic              chk_n
);
    byte_t st_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) st_q[g] <= '0;
            else     st_q[g] <= (clr[g] ? '0 : st_q[g]) | evt[g*DATA_W +: DATA_W];
        end
        assign status[g*DATA_W +: DATA_W] = st_q[g];
    end

    assign chk_n = ~|(status & ~mask);
endmodule

// File: rtl/smr_meas_chan.sv
module smr_meas_chan
    import smr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  meas_t val,
    input  logic  cap,
    output meas_t live,
    output meas_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            held <= '0;
        end else begin
            if (upd) live <= val;
            if (cap) held <= live;
        end
    end
endmodule

// File: rtl/stat_meas_rdport.sv
module stat_meas_rdport
    import smr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [STAT_W-1:0]                evt,
    input  logic [STAT_W-1:0]                irq_mask,
    input  logic [NUM_MEAS-1:0]              meas_upd,
    input  logic [NUM_MEAS-1:0][MEAS_W-1:0]  meas_val,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             rd_vld,
    output logic                             chk_n
);
    rd_dec_t                   dec;
    logic [STAT_W-1:0]         status_q;
    logic [STAT_BYTES-1:0]     rd_clr;
    logic [NUM_MEAS-1:0]       cap;
    meas_t                     live [NUM_MEAS];
    meas_t                     held [NUM_MEAS];
    byte_t                     nxt;

    smr_rd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .dec     (dec)
    );

    for (genvar j = 0; j < STAT_BYTES; j++) begin : g_clr
        assign rd_clr[j] = dec.act && dec.sel == SEL_STAT && dec.idx == IDX_W'(j);
    end

    smr_stat_bank #(.NBYTES(STAT_BYTES)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .mask   (irq_mask),
        .clr    (rd_clr),
        .status (status_q),
        .chk_n  (chk_n)
    );

    for (genvar i = 0; i < NUM_MEAS; i++) begin : g_meas
        assign cap[i] = dec.act && dec.sel == SEL_MHI && dec.idx == IDX_W'(i);
        smr_meas_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .upd  (meas_upd[i]),
            .val  (meas_val[i]),
            .cap  (cap[i]),
            .live (live[i]),
            .held (held[i])
        );
    end

    // read byte select: upper half from live value, lower half from snapshot
    always_comb begin
        nxt = '0;
        unique case (dec.sel)
            SEL_STAT: begin
                for (int i = 0; i < STAT_BYTES; i++)
                    if (dec.idx == IDX_W'(i)) nxt = status_q[i*DATA_W +: DATA_W];
            end
            SEL_MHI: begin
                for (int i = 0; i < NUM_MEAS; i++)
                    if (dec.idx == IDX_W'(i)) nxt = hi_byte(live[i]);
            end
            SEL_MLO: begin
                for (int i = 0; i < NUM_MEAS; i++)
                    if (dec.idx == IDX_W'(i)) nxt = lo_byte(held[i]);
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_data <= dec.act ? nxt : '0;
            rd_vld  <= dec.act;
        end
    end
endmodule

// File: rtl/smr_chk.sv
module smr_chk
    import smr_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    rd_en,
    input logic [STAT_W-1:0]       evt,
    input logic [STAT_W-1:0]       irq_mask,
    input logic                    chk_n,
    input logic                    rd_vld,
    input logic [STAT_W-1:0]       status,
    input logic [STAT_BYTES-1:0]   rd_clr,
    input logic [NUM_MEAS-1:0]     cap,
    input meas_t                   held [NUM_MEAS]
);
    // R2: an unmasked event drives the interrupt low next cycle if the mask held
    a_r2_irq_follows_evt: assert property (@(posedge clk) disable iff (rst)
        (|(evt & ~irq_mask)) |=> (!$stable(irq_mask) || !chk_n));

    // R3: every event bit is visible as set one cycle later, read or not
    a_r3_evt_sticks: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    // R9: a read cycle is followed by a valid byte
    a_r9_vld_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);

    a_r9_no_vld_idle: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !$past(rst)) |=> !rd_vld);

    for (genvar j = 0; j < STAT_BYTES; j++) begin : g_stat
        // R4: a read with no colliding event empties the byte
        a_r4_clear_on_read: assert property (@(posedge clk) disable iff (rst)
            (rd_clr[j] && evt[j*DATA_W +: DATA_W] == '0) |=> (status[j*DATA_W +: DATA_W] == '0));
        // R4: without read or event the byte keeps its bits
        a_r4_hold_unread: assert property (@(posedge clk) disable iff (rst)
            (!rd_clr[j] && evt[j*DATA_W +: DATA_W] == '0) |=> $stable(status[j*DATA_W +: DATA_W]));
    end

    for (genvar i = 0; i < NUM_MEAS; i++) begin : g_meas
        // R7: snapshot changes only after an upper-byte read
        a_r7_snapshot_stable: assert property (@(posedge clk) disable iff (rst)
            !cap[i] |=> $stable(held[i]));
    end
endmodule

bind stat_meas_rdport smr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .evt      (evt),
    .irq_mask (irq_mask),
    .chk_n    (chk_n),
    .rd_vld   (rd_vld),
    .status   (status_q),
    .rd_clr   (rd_clr),
    .cap      (cap),
    .held     (held)
);

// File: tb/tb_stat_meas_rdport.sv
`timescale 1ns/1ps
module tb_stat_meas_rdport;
    logic             clk = 1'b0;
    logic             rst;
    logic             rd_en;
    logic [5:0]       rd_addr;
    logic [23:0]      evt;
    logic [23:0]      irq_mask;
    logic [1:0]       meas_upd;
    logic [1:0][9:0]  meas_val;
    logic [7:0]       rd_data;
    logic             rd_vld;
    logic             chk_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [7:0] m_stat [3];
    logic [9:0] m_live [2];
    logic [9:0] m_hold [2];
    logic [5:0] m_cnt;
    bit         m_req;

    always #2.5 clk = ~clk;

    stat_meas_rdport dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .evt(evt),
        .irq_mask(irq_mask), .meas_upd(meas_upd), .meas_val(meas_val),
        .rd_data(rd_data), .rd_vld(rd_vld), .chk_n(chk_n)
    );

    function automatic logic [7:0] exp_byte(logic [5:0] a);
        if (a < 3)  return m_stat[a];
        case (a)
            6'd3: return {6'd0, m_live[0][9:8]};
            6'd4: return m_hold[0][7:0];
            6'd5: return {6'd0, m_live[1][9:8]};
            6'd6: return m_hold[1][7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_chk_n(logic [23:0] mk);
        return ~|({m_stat[2], m_stat[1], m_stat[0]} & ~mk);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit re, input logic [5:0] ad, input logic [23:0] ev,
                        input logic [23:0] mk, input logic [1:0] up,
                        input logic [9:0] u0, input logic [9:0] u1, input string tag);
        logic [5:0] ea;
        logic [7:0] eb;
        rd_en = re; rd_addr = ad; evt = ev; irq_mask = mk;
        meas_upd = up; meas_val[0] = u0; meas_val[1] = u1;
        ea = (re && !m_req) ? ad : m_cnt;
        eb = re ? exp_byte(ea) : 8'h00;
        if (re) begin
            if (ea < 3) m_stat[ea] = 8'h00;
            if (ea == 6'd3) m_hold[0] = m_live[0];
            if (ea == 6'd5) m_hold[1] = m_live[1];
            m_cnt = ea + 6'd1;
        end
        m_req = re;
        for (int b = 0; b < 3; b++) m_stat[b] = m_stat[b] | ev[b*8 +: 8];
        if (up[0]) m_live[0] = u0;
        if (up[1]) m_live[1] = u1;
        @(posedge clk); #1;
        check(tag, "rd_vld", int'(rd_vld), int'(re));
        check(tag, "rd_data", int'(rd_data), int'(eb));
        check("R2", "chk_n", int'(chk_n), int'(exp_chk_n(mk)));
    endtask

    task automatic idle(input logic [23:0] mk, input string tag);
        step(0, 6'd0, 24'd0, mk, 2'b00, 10'd0, 10'd0, tag);
    endtask

    initial begin
        #500us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst = 1'b1; rd_en = 0; rd_addr = 0; evt = 0; irq_mask = 0; meas_upd = 0; meas_val = '0;
        for (int b = 0; b < 3; b++) m_stat[b] = 8'h00;
        for (int i = 0; i < 2; i++) begin m_live[i] = 0; m_hold[i] = 0; end
        m_cnt = 0; m_req = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state
        check("R1", "rd_vld", int'(rd_vld), 0);
        check("R1", "rd_data", int'(rd_data), 0);
        check("R1", "chk_n", int'(chk_n), 1);
        // R1: measurement and snapshot zero, burst 0x03..0x06
        step(1, 6'd3, 0, 0, 0, 0, 0, "R1");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R1");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R1");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R1");
        idle(0, "R9");

        // R2: event drives chk_n low; masking hides it
        step(0, 0, 24'h000004, 24'h0, 0, 0, 0, "R3");
        idle(24'h0, "R2");
        idle(24'h000004, "R2");
        check("R2", "chk_n masked", int'(chk_n), 1);
        // R4: read of byte 0 returns 0x04 and clears
        step(1, 6'd0, 0, 24'h0, 0, 0, 0, "R4");
        idle(24'h0, "R4");
        check("R4", "chk_n after clear", int'(chk_n), 1);
        // R3: event on byte 1 in same cycle as its read survives
        step(0, 0, 24'h000200, 0, 0, 0, 0, "R3");
        step(1, 6'd1, 24'h000100, 0, 0, 0, 0, "R3");
        idle(0, "R3");
        step(1, 6'd1, 0, 0, 0, 0, 0, "R3");
        idle(0, "R3");
        // R4: reading another byte leaves byte 2 set
        step(0, 0, 24'h800000, 0, 0, 0, 0, "R4");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R4");
        idle(0, "R4");
        step(1, 6'd2, 0, 0, 0, 0, 0, "R4");
        idle(0, "R4");

        // R6: update then read next cycle
        step(0, 0, 0, 0, 2'b11, 10'h2A5, 10'h15A, "R6");
        step(1, 6'd3, 0, 0, 0, 0, 0, "R6");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R6");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R6");
        step(1, 6'd0, 0, 0, 0, 0, 0, "R6");
        idle(0, "R6");
        // R7: update lands between upper and lower byte reads
        step(1, 6'd3, 0, 0, 2'b01, 10'h3C3, 0, "R7");
        step(1, 6'd0, 0, 0, 2'b01, 10'h111, 0, "R7");
        idle(0, "R7");
        // R7: lone lower-byte read returns last snapshot
        step(1, 6'd4, 0, 0, 0, 0, 0, "R7");
        idle(0, "R7");
        // R8 / R5: wrap from 0x3E to 0x00 and unmapped reads
        step(0, 0, 24'h010000, 0, 0, 0, 0, "R8");
        step(1, 6'h3E, 0, 0, 0, 0, 0, "R5");
        step(1, 6'h11, 0, 0, 0, 0, 0, "R8");
        step(1, 6'h22, 0, 0, 0, 0, 0, "R8");
        step(1, 6'h33, 0, 0, 0, 0, 0, "R8");
        step(1, 6'h00, 0, 0, 0, 0, 0, "R8");
        idle(0, "R8");
        step(1, 6'd7, 0, 0, 0, 0, 0, "R5");
        idle(0, "R5");

        // constrained random traffic
        begin
            bit         inb = 0;
            logic [23:0] mk = 0;
            for (int n = 0; n < 4000; n++) begin
                bit         re;
                logic [5:0] ad;
                logic [23:0] ev;
                logic [1:0] up;
                if (inb) inb = ($urandom % 5) != 0;
                else     inb = ($urandom % 4) == 0;
                re = inb;
                ad = (($urandom % 8) == 0) ? 6'($urandom) : 6'($urandom % 8);
                ev = (($urandom % 6) == 0) ? (24'd1 << ($urandom % 24)) : 24'd0;
                if (($urandom % 50) == 0) mk = 24'($urandom) & 24'($urandom);
                up = 2'($urandom) & 2'($urandom);
                step(re, ad, ev, mk, up, 10'($urandom), 10'($urandom), "R8");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule